// File: doc/BRIEF.md
# PLL Multiplier Code Converter

This block translates a PLL feedback multiplier between its plain binary value and the scrambled form that the PLL's multiplier register expects. That register does not hold the multiplier as a binary number. It holds a position in a 15-bit shift-register sequence. To encode, the block starts from a fixed seed and steps the sequence forward a number of times that depends on the multiplier. To decode, it steps a code backward toward the seed and counts the steps. Each conversion moves one step per clock. Software or a configuration sequencer pulses `start` with the mode and operand, waits for `done`, and then reads the result.

In the encode direction the block also derives two loop-bandwidth fields from the binary multiplier: a proportional field and an integral field. It packs them together with the 17-bit code into one 32-bit control word. `MAX_MULT` sets the largest multiplier. The default of 32768 gives the full-size converter, and smaller values shorten the walk for reduced configurations.

Top module: `pll_mcode_conv`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `word_out` and `mult_out` are zero.
- R2: Encoding (`decode`=0) maps multiplier 0 to code 0, 1 to 0x18003 and 2 to 0x10003, and `done` rises in the first cycle after the start cycle.
- R3: For 3 <= M <= MAX_MULT, the encoded code is the result of applying MAX_MULT+1-M forward steps to 0x4000. A forward step sets bit 14 to bit0 XOR bit1 and shifts bits 14:1 down by one. `done` rises MAX_MULT+2-M cycles after the start cycle.
- R4: The proportional field in `word_out[21:17]` is (M>>1)+1 when M < 60, and 31 otherwise.
- R5: For M >= 501, the integral field in `word_out[27:22]` is 1 when M > 16384, 2 when M > 8192, 4 when M > 2048, and 8 otherwise.
- R6: For M < 501, the integral field is (M & 0x3C)+4 when M < 60. For M from 60 up, let t = floor(1024/(M+9)). The field is 4*t when M+9 divides 1024 exactly, and 4*(t+1) otherwise.
- R7: The code occupies `word_out[16:0]`, and `word_out[31:28]` is always zero.
- R8: An encode request with M > MAX_MULT finishes one cycle after start with `err`=1 and `word_out`=0.
- R9: Decoding (`decode`=1) maps code 0x18003 to 1 and 0x10003 to 2, with `done` in the first cycle after start.
- R10: Any other code is decoded by reverse steps, which set bit 0 to bit0 XOR bit14 and shift bits 13:0 up within 15 bits. The code is first compared with 0x4000 and is stepped only while it differs. A counter loaded with MAX_MULT+1 drops by one per step. `mult_out` receives the counter when the code equals 0x4000, with `err`=0, and `done` follows k+1 cycles after start for k steps.
- R11: If the counter reaches 0 before the code equals 0x4000, the decode ends with `err`=1 and `mult_out`=0, MAX_MULT+2 cycles after start.
- R12: `done` is a one-cycle pulse with `busy` low. Results hold until the next completion, and `start` is ignored while `busy` is high.
- R13: An encode leaves `mult_out` unchanged, and a decode leaves `word_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion; taken only when idle |
| decode | input | 1 | Mode: 0 encodes `mult_in`, 1 decodes `code_in` |
| mult_in | input | MW | Binary multiplier to encode (MW = clog2(MAX_MULT+2)) |
| code_in | input | 17 | Scrambled code to decode |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Out-of-range multiplier or undecodable code |
| word_out | output | 32 | Packed control word: integral field, proportional field, code |
| mult_out | output | MW | Decoded binary multiplier |

## Verification
The bench sweeps the highest multipliers of the full-size instance through encode and then decode. This separates step-count errors and off-by-one latency from errors in the shift feedback itself. A reduced instance makes the low multipliers affordable. On it, the multipliers sit on each edge of the bandwidth-field breakpoints, including the values where M+9 divides 1024 exactly and the values just next to them, so each branch of the field rules is selected at least once. The special codes, an out-of-range multiplier, a code carrying stray upper bits, and the all-zero code that never reaches the seed are each run on their own. A start pulse injected mid-walk checks that a running conversion is not disturbed.

// File: rtl/pll_mcode_conv.sv
`timescale 1ns/1ps
module pll_mcode_conv #(
  parameter int MAX_MULT = 32768,
  localparam int MW = $clog2(MAX_MULT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          decode,
  input  logic [MW-1:0] mult_in,
  input  logic [16:0]   code_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   word_out,
  output logic [MW-1:0] mult_out
);

  localparam int TOP = MAX_MULT + 1;
  localparam logic [16:0] SEED  = 17'h04000;
  localparam logic [16:0] CODE1 = 17'h18003;
  localparam logic [16:0] CODE2 = 17'h10003;

  function automatic logic [4:0] selp_of(input logic [31:0] m);
    logic [31:0] r;
    r = (m < 32'd60) ? (m >> 1) + 32'd1 : 32'd31;
    return r[4:0];
  endfunction

  function automatic logic [5:0] seli_of(input logic [31:0] m);
    logic [31:0] d, t, r;
    d = m + 32'd9;
    t = 32'd1024 / d;
    if (m > 32'd16384)     r = 32'd1;
    else if (m > 32'd8192) r = 32'd2;
    else if (m > 32'd2048) r = 32'd4;
    else if (m >= 32'd501) r = 32'd8;
    else if (m >= 32'd60)  r = (t * d == 32'd1024) ? t * 32'd4 : (t + 32'd1) * 32'd4;
    else                   r = (m & 32'h3c) + 32'd4;
    return r[5:0];
  endfunction

  logic          dec_q, bad_q;
  logic [16:0]   x_q;
  logic [MW-1:0] cnt_q;
  logic [4:0]    selp_q;
  logic [5:0]    seli_q;

  wire [31:0] m32   = 32'(mult_in);
  wire [31:0] steps = 32'(TOP) - m32;
  wire        over  = m32 > 32'(MAX_MULT);
  wire        hit   = (x_q == SEED);
  wire        zero  = (cnt_q == '0);
  wire        fin   = dec_q ? (hit || zero) : zero;
  wire [16:0] fwd   = {2'b00, x_q[0] ^ x_q[1], x_q[14:1]};
  wire [16:0] rev   = {2'b00, x_q[13:0], x_q[0] ^ x_q[14]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      word_out <= '0; mult_out <= '0;
      dec_q <= 1'b0; bad_q <= 1'b0; x_q <= '0; cnt_q <= '0;
      selp_q <= '0; seli_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          dec_q <= decode;
          if (decode) begin
            bad_q <= 1'b0;
            if (code_in == CODE1) begin
              x_q <= SEED; cnt_q <= MW'(1);
            end else if (code_in == CODE2) begin
              x_q <= SEED; cnt_q <= MW'(2);
            end else begin
              x_q <= code_in; cnt_q <= TOP[MW-1:0];
            end
          end else begin
            bad_q  <= over;
            selp_q <= selp_of(m32);
            seli_q <= seli_of(m32);
            cnt_q  <= '0;
            if (over || m32 == 32'd0) x_q <= '0;
            else if (m32 == 32'd1)    x_q <= CODE1;
            else if (m32 == 32'd2)    x_q <= CODE2;
            else begin
              x_q   <= SEED;
              cnt_q <= steps[MW-1:0];
            end
          end
        end
      end else if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (dec_q) begin
          mult_out <= hit ? cnt_q : '0;
          err      <= !hit;
        end else begin
          err      <= bad_q;
          word_out <= bad_q ? 32'd0 : {4'b0000, seli_q, selp_q, x_q};
        end
      end else begin
        x_q   <= dec_q ? rev : fwd;
        cnt_q <= cnt_q - MW'(1);
      end
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R12
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(word_out));
  // R12
  mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(mult_out));
  // R7
  word_top_chk: assert property (@(posedge clk) disable iff (!rst_n) word_out[31:28] == 4'h0);
  // R13
  enc_keeps_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dec_q) |-> $stable(mult_out));

endmodule

// File: tb/pll_mcode_conv_tb.sv
`timescale 1ns/1ps
module pll_mcode_conv_tb;
  localparam int MAXA = 32768;
  localparam int MAXB = 8200;
  localparam int MWA = $clog2(MAXA + 2);
  localparam int MWB = $clog2(MAXB + 2);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_a = 1'b0, start_b = 1'b0, dec = 1'b0;
  logic [16:0] code = '0;
  logic [MWA-1:0] m_a = '0;
  logic [MWB-1:0] m_b = '0;
  logic busy_a, done_a, err_a, busy_b, done_b, err_b;
  logic [31:0] word_a, word_b;
  logic [MWA-1:0] mult_a;
  logic [MWB-1:0] mult_b;

  pll_mcode_conv #(.MAX_MULT(MAXA)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .decode(dec), .mult_in(m_a),
    .code_in(code), .busy(busy_a), .done(done_a), .err(err_a),
    .word_out(word_a), .mult_out(mult_a));

  pll_mcode_conv #(.MAX_MULT(MAXB)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .start(start_b), .decode(dec), .mult_in(m_b),
    .code_in(code), .busy(busy_b), .done(done_b), .err(err_b),
    .word_out(word_b), .mult_out(mult_b));

  int nvec = 0, nbad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      nbad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] code_of(input int m);
    logic [31:0] x;
    if (m == 0) return 32'h0;
    if (m == 1) return 32'h18003;
    if (m == 2) return 32'h10003;
    x = 32'h4000;
    for (int i = 0; i < MAXA + 1; i++) if (i < 0) x = 0;
    return x;
  endfunction

  function automatic logic [31:0] enc_code(input int m, input int mx);
    logic [31:0] x;
    if (m <= 2) return code_of(m);
    x = 32'h4000;
    for (int i = 0; i < mx + 1 - m; i++)
      x = (((x ^ (x >> 1)) & 32'd1) << 14) | (x >> 1);
    return x;
  endfunction

  function automatic logic [31:0] selp_e(input int m);
    return (m < 60) ? 32'((m / 2) + 1) : 32'd31;
  endfunction

  function automatic logic [31:0] seli_e(input int m);
    int t;
    if (m > 16384) return 32'd1;
    if (m > 8192) return 32'd2;
    if (m > 2048) return 32'd4;
    if (m >= 501) return 32'd8;
    if (m >= 60) begin
      t = 1024 / (m + 9);
      return (1024 % (m + 9) == 0) ? 32'(4 * t) : 32'(4 * (t + 1));
    end
    return 32'((m & 'h3c) + 4);
  endfunction

  task automatic run(input bit b, input bit d, input int m, input logic [16:0] c,
                     input bit inj, output int lat);
    @(negedge clk);
    dec = d; code = c;
    if (b) begin m_b = m[MWB-1:0]; start_b = 1'b1; end
    else begin m_a = m[MWA-1:0]; start_a = 1'b1; end
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (inj && lat == 10) begin
        dec = ~d; code = 17'h18003; m_a = 5; m_b = 5;
        if (b) start_b = 1'b1; else start_a = 1'b1;
      end else begin
        start_a = 1'b0; start_b = 1'b0;
      end
    end while (!(b ? done_b : done_a) && lat < 40000);
  endtask

  task automatic do_enc(input bit b, input int m, input string tag, input bit inj = 1'b0);
    int mx, lat, elat;
    logic [31:0] ew, w;
    logic e, ee;
    mx = b ? MAXB : MAXA;
    run(b, 1'b0, m, '0, inj, lat);
    w = b ? word_b : word_a;
    e = b ? err_b : err_a;
    if (m > mx) begin ew = 0; ee = 1'b1; elat = 1; end
    else begin
      ew = (seli_e(m) << 22) | (selp_e(m) << 17) | enc_code(m, mx);
      ee = 1'b0;
      elat = (m <= 2) ? 1 : mx + 2 - m;
    end
    chk($sformatf("%s word M=%0d", tag, m), 64'(w), 64'(ew));
    chk($sformatf("%s err M=%0d", tag, m), 64'(e), 64'(ee));
    chk($sformatf("%s latency M=%0d", tag, m), 64'(lat), 64'(elat));
  endtask

  task automatic do_dec(input bit b, input logic [16:0] c, input string tag);
    int mx, lat, elat, i, em;
    logic [31:0] x;
    logic ee;
    mx = b ? MAXB : MAXA;
    if (c == 17'h18003) begin em = 1; ee = 1'b0; elat = 1; end
    else if (c == 17'h10003) begin em = 2; ee = 1'b0; elat = 1; end
    else begin
      x = 32'(c); i = mx + 1; elat = 1;
      while (x != 32'h4000 && i > 0) begin
        x = ((x ^ (x >> 14)) & 32'd1) | ((x << 1) & 32'h7fff);
        i--; elat++;
      end
      ee = (x != 32'h4000);
      em = ee ? 0 : i;
    end
    run(b, 1'b1, 0, c, 1'b0, lat);
    chk($sformatf("%s mult code=%0h", tag, c), 64'(b ? 32'(mult_b) : 32'(mult_a)), 64'(em));
    chk($sformatf("%s err code=%0h", tag, c), 64'(b ? err_b : err_a), 64'(ee));
    chk($sformatf("%s latency code=%0h", tag, c), 64'(lat), 64'(elat));
  endtask

  initial begin
    logic [31:0] w0;
    logic [MWA-1:0] keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'({busy_a, busy_b}), 0);
    chk("R1 done", 64'({done_a, done_b}), 0);
    chk("R1 err", 64'({err_a, err_b}), 0);
    chk("R1 word", 64'({word_a, word_b}), 0);
    chk("R1 mult", 64'({mult_a, mult_b}), 0);
    rst_n = 1'b1;

    // R2 special encodings
    for (int m = 0; m <= 2; m++) do_enc(1'b0, m, "R2");
    // R8 out of range
    do_enc(1'b0, 40000, "R8");
    do_enc(1'b1, MAXB + 1, "R8");
    // R9 special decodes
    do_dec(1'b0, 17'h18003, "R9");
    do_dec(1'b1, 17'h10003, "R9");

    // R3 R10 top sweep on full size, encode then decode back
    for (int m = MAXA; m > MAXA - 32; m--) begin
      do_enc(1'b0, m, "R3");
      do_dec(1'b0, enc_code(m, MAXA)[16:0], "R10");
    end
    // R13 encode keeps mult_out, decode keeps word_out
    keep = mult_a;
    do_enc(1'b0, MAXA - 3, "R13");
    chk("R13 mult kept across encode", 64'(mult_a), 64'(keep));
    w0 = word_a;
    do_dec(1'b0, 17'h18003, "R13");
    chk("R13 word kept across decode", 64'(word_a), 64'(w0));

    // R5 upper integral breakpoints on full size
    do_enc(1'b0, 16385, "R5");
    do_enc(1'b0, 16384, "R5");
    // R5 R6 R4 breakpoints on the reduced instance
    do_enc(1'b1, 8193, "R5");
    do_enc(1'b1, 8192, "R5");
    do_enc(1'b1, 2049, "R5");
    do_enc(1'b1, 2048, "R5");
    do_enc(1'b1, 501, "R5");
    do_enc(1'b1, 500, "R6");
    do_enc(1'b1, 248, "R6");
    do_enc(1'b1, 247, "R6");
    do_enc(1'b1, 119, "R6");
    do_enc(1'b1, 60, "R4");
    do_enc(1'b1, 3, "R4");
    for (int m = MAXB; m > MAXB - 8; m--) do_enc(1'b1, m, "R7");

    // R12 start ignored while busy; result held after done
    do_enc(1'b1, 59, "R12", 1'b1);
    w0 = word_b;
    repeat (3) @(negedge clk);
    chk("R12 done one cycle", 64'(done_b), 0);
    chk("R12 word held", 64'(word_b), 64'(w0));

    // R10 round trips and a code with stray upper bits
    do_dec(1'b1, enc_code(8193, MAXB)[16:0], "R10");
    do_dec(1'b1, enc_code(2049, MAXB)[16:0], "R10");
    do_dec(1'b1, enc_code(59, MAXB)[16:0], "R10");
    do_dec(1'b1, 17'h14000, "R10");
    // R11 code that never reaches the seed
    do_dec(1'b1, 17'h00000, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule